// File: doc/BRIEF.md
# Memory protection region checker

This block decides which of read, write and execute an access may use, given the access's byte address and whether the hart runs in machine mode or user mode. It holds sixteen protection regions. Each region has an 8-bit configuration byte and a 30-bit word-address register. A region is either switched off, matches one exact 32-bit word, or matches a naturally aligned power-of-two span. The span's size is encoded by the count of trailing ones in the address register. When several regions cover the address, the lowest-numbered one decides the result.

The same block owns the register write path. Configuration bytes are packed four to a 32-bit word. Address registers are written one at a time. A region whose lock bit is set refuses every further write to its configuration byte and to its address register until reset. A locked region also applies its permissions to machine mode. The lookup and the register read-back are combinational over the current register contents. Writes land on the rising clock edge.

Top module: `memprot_unit`

## Requirements
- R1: After reset every configuration byte and address register reads 0 and no access hits: machine mode gets 3'b111 and user mode 3'b000.
- R2: A region whose mode field (configuration bits 4:3) is 0 never matches, whatever its address register holds.
- R3: A region in mode 1 or mode 2 matches exactly when acc_addr[31:2] equals its 30-bit address register; acc_addr[1:0] play no part.
- R4: A region in mode 3 compares only the bits above position t, where t is the number of trailing ones in its address register. Bits t down to 0 are don't-care. When t is 29 or 30 (all ones), the region matches every address.
- R5: When several regions match, the lowest-numbered one wins. acc_hit is 1 and acc_region gives its index. With no match, acc_hit is 0 and acc_region is 0.
- R6: On a match, machine mode with the region unlocked (bit 7 clear) gets 3'b111. In every other case the result is the region's configuration bits 2:0 (bit 0 read, bit 1 write, bit 2 execute), and this includes machine mode on a locked region.
- R7: With no matching region, machine mode gets 3'b111 and user mode gets 3'b000.
- R8: A write with wr_kind 0 and wr_idx g (0 to 3) puts byte k of wr_data (bits 8k+7:8k) into region 4g+k, ANDed with 8'h9F so that bits 6:5 always read 0. A read with rd_kind 0 and rd_idx g returns the same packing. A configuration write with wr_idx of 4 or more changes nothing, and a configuration read with rd_idx of 4 or more returns 0.
- R9: A write with wr_kind 1 stores wr_data[29:0] into the address register of region wr_idx. A read with rd_kind 1 returns {2'b00, register}.
- R10: A locked region ignores configuration and address writes. Unlocked regions sharing its configuration word still take their bytes. Only reset clears a lock.
- R11: Writes take effect at the rising clock edge. A lookup or read in the same cycle as a write sees the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 1 | 0: configuration word, 1: address register |
| wr_idx | input | 4 | Configuration word number or region number |
| wr_data | input | 32 | Write data |
| rd_kind | input | 1 | 0: configuration word, 1: address register |
| rd_idx | input | 4 | Configuration word number or region number to read |
| rd_data | output | 32 | Read-back data (combinational) |
| acc_addr | input | 32 | Byte address of the access being checked |
| acc_mach | input | 1 | 1: machine mode, 0: user mode |
| acc_perm | output | 3 | Granted permissions {execute, write, read} |
| acc_hit | output | 1 | Some enabled region covers acc_addr |
| acc_region | output | 4 | Index of the deciding region, 0 on no hit |

## Verification
A register write and a lookup of the address it affects can fall in the same cycle. The bench provokes this by driving the write strobe and the probe address on the same falling edge, once to enable a region and once to move a region's address. It samples the lookup before the rising edge and expects the old result. It samples again after the edge and expects the new one. A write to a locked region that coincides with a lookup of that region is judged the same way, except that the result must be identical on both sides of the edge. All other lookups are compared against an arithmetic model that counts trailing ones with a loop. The bench runs that comparison over a sweep of every span size and over a long pseudo-random mix of writes and probes.

// File: rtl/memprot_pkg.sv
package memprot_pkg;

    localparam int CFG_W = 8;
    localparam logic [CFG_W-1:0] CFG_KEEP = 8'h9F;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_WORD_A = 2'd1,
        MODE_WORD_B = 2'd2,
        MODE_POW2   = 2'd3
    } match_mode_e;

    typedef enum logic {
        SEL_CFG  = 1'b0,
        SEL_ADDR = 1'b1
    } csr_sel_e;

    typedef struct packed {
        logic        lock;
        logic [1:0]  rsvd;
        match_mode_e mode;
        logic [2:0]  xwr;
    } region_cfg_t;

endpackage

// File: rtl/memprot_region.sv
module memprot_region
    import memprot_pkg::*;
#(
    parameter int WA_W = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic            addr_we,
    input  logic [WA_W-1:0] addr_wdata,
    input  logic [WA_W-1:0] acc_word,
    output region_cfg_t     cfg_q,
    output logic [WA_W-1:0] addr_q,
    output logic            hit
);

    logic [WA_W-1:0] span_mask;
    logic [WA_W-1:0] cmp_mask;
    logic            enabled;

    // A locked region keeps its contents until reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            addr_q <= '0;
        end else if (!cfg_q.lock) begin
            if (cfg_we) begin
                cfg_q <= region_cfg_t'(cfg_wdata & CFG_KEEP);
            end
            if (addr_we) begin
                addr_q <= addr_wdata;
            end
        end
    end

    // Bits up to and including the lowest zero are don't-care.
    assign span_mask = ~(addr_q ^ (addr_q + WA_W'(1)));

    always_comb begin
        unique case (cfg_q.mode)
            MODE_OFF: begin
                enabled  = 1'b0;
                cmp_mask = '1;
            end
            MODE_WORD_A, MODE_WORD_B: begin
                enabled  = 1'b1;
                cmp_mask = '1;
            end
            MODE_POW2: begin
                enabled  = 1'b1;
                cmp_mask = span_mask;
            end
        endcase
    end

    assign hit = enabled && (((acc_word ^ addr_q) & cmp_mask) == '0);

endmodule

// File: rtl/memprot_select.sv
module memprot_select #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     hit_vec,
    output logic             any_hit,
    output logic [IDX_W-1:0] first
);

    assign any_hit = |hit_vec;

    // Scan downwards so the lowest index is written last.
    always_comb begin
        first = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                first = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/memprot_grant.sv
module memprot_grant
    import memprot_pkg::*;
(
    input  logic        any_hit,
    input  logic        mach,
    input  region_cfg_t sel_cfg,
    output logic [2:0]  perm
);

    always_comb begin
        unique case ({any_hit, mach})
            2'b00: perm = 3'b000;
            2'b01: perm = 3'b111;
            2'b10: perm = sel_cfg.xwr;
            2'b11: perm = sel_cfg.lock ? sel_cfg.xwr : 3'b111;
        endcase
    end

endmodule

// File: rtl/memprot_unit.sv
module memprot_unit
    import memprot_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int XLEN  = 32,
    localparam int WA_W  = XLEN - 2,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_kind,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]  wr_data,
    input  logic             rd_kind,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [XLEN-1:0]  rd_data,
    input  logic [XLEN-1:0]  acc_addr,
    input  logic             acc_mach,
    output logic [2:0]       acc_perm,
    output logic             acc_hit,
    output logic [IDX_W-1:0] acc_region
);

    localparam int BPW  = XLEN / CFG_W;
    localparam int NGRP = NREG / BPW;

    region_cfg_t           cfg_all  [NREG];
    logic [WA_W-1:0]       addr_all [NREG];
    logic [NREG-1:0]       hit_vec;
    logic [NREG*CFG_W-1:0] cfg_flat;
    logic [NREG*WA_W-1:0]  addr_flat;
    region_cfg_t           sel_cfg;
    logic                  unused_low;

    assign unused_low = ^acc_addr[1:0];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam int GRP  = i / BPW;
        localparam int LANE = i % BPW;

        logic cfg_we_i;
        logic addr_we_i;

        assign cfg_we_i  = wr_en && (wr_kind == SEL_CFG)  && (wr_idx == IDX_W'(GRP));
        assign addr_we_i = wr_en && (wr_kind == SEL_ADDR) && (wr_idx == IDX_W'(i));

        memprot_region #(
            .WA_W(WA_W)
        ) u_region (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (cfg_we_i),
            .cfg_wdata (wr_data[LANE*CFG_W +: CFG_W]),
            .addr_we   (addr_we_i),
            .addr_wdata(wr_data[WA_W-1:0]),
            .acc_word  (acc_addr[XLEN-1:2]),
            .cfg_q     (cfg_all[i]),
            .addr_q    (addr_all[i]),
            .hit       (hit_vec[i])
        );

        assign cfg_flat[i*CFG_W +: CFG_W] = cfg_all[i];
        assign addr_flat[i*WA_W +: WA_W]  = addr_all[i];
    end

    // Read-back over the current contents.
    always_comb begin
        rd_data = '0;
        if (rd_kind == SEL_ADDR) begin
            rd_data = XLEN'(addr_all[rd_idx]);
        end else begin
            for (int g = 0; g < NGRP; g++) begin
                if (rd_idx == IDX_W'(g)) begin
                    for (int l = 0; l < BPW; l++) begin
                        rd_data[l*CFG_W +: CFG_W] = cfg_all[g*BPW + l];
                    end
                end
            end
        end
    end

    memprot_select #(
        .N    (NREG),
        .IDX_W(IDX_W)
    ) u_select (
        .hit_vec(hit_vec),
        .any_hit(acc_hit),
        .first  (acc_region)
    );

    assign sel_cfg = cfg_all[acc_region];

    memprot_grant u_grant (
        .any_hit(acc_hit),
        .mach   (acc_mach),
        .sel_cfg(sel_cfg),
        .perm   (acc_perm)
    );

endmodule

// File: rtl/memprot_unit_chk.sv
module memprot_unit_chk
    import memprot_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int XLEN  = 32,
    localparam int WA_W  = XLEN - 2,
    localparam int IDX_W = $clog2(NREG)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic                  wr_kind,
    input logic [IDX_W-1:0]      wr_idx,
    input logic                  acc_mach,
    input logic [2:0]            acc_perm,
    input logic                  acc_hit,
    input logic [IDX_W-1:0]      acc_region,
    input logic [NREG*CFG_W-1:0] cfg_flat,
    input logic [NREG*WA_W-1:0]  addr_flat
);

    localparam int BPW = XLEN / CFG_W;

    logic [NREG-1:0]  lock_vec;
    logic [CFG_W-1:0] hit_cfg;

    always_comb begin
        for (int r = 0; r < NREG; r++) begin
            lock_vec[r] = cfg_flat[r*CFG_W + 7];
        end
    end

    assign hit_cfg = cfg_flat[int'(acc_region)*CFG_W +: CFG_W];

    // R7
    nomatch_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_hit |-> acc_perm == (acc_mach ? 3'b111 : 3'b000));

    // R6
    mach_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_hit && acc_mach && !hit_cfg[7]) |-> acc_perm == 3'b111);

    // R6
    field_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_hit && (!acc_mach || hit_cfg[7])) |-> acc_perm == hit_cfg[2:0]);

    // R2
    hit_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_hit |-> hit_cfg[4:3] != 2'b00);

    // R10
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_vec & $past(lock_vec)) == $past(lock_vec));

    for (genvar r = 0; r < NREG; r++) begin : g_hold
        // R10
        addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_kind == SEL_ADDR && wr_idx == IDX_W'(r) && lock_vec[r])
            |=> $stable(addr_flat[r*WA_W +: WA_W]));

        // R10
        cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_kind == SEL_CFG && wr_idx == IDX_W'(r / BPW) && lock_vec[r])
            |=> $stable(cfg_flat[r*CFG_W +: CFG_W]));

        // R8
        rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_flat[r*CFG_W + 5 +: 2] == 2'b00);
    end

endmodule

bind memprot_unit memprot_unit_chk #(
    .NREG(NREG),
    .XLEN(XLEN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_kind   (wr_kind),
    .wr_idx    (wr_idx),
    .acc_mach  (acc_mach),
    .acc_perm  (acc_perm),
    .acc_hit   (acc_hit),
    .acc_region(acc_region),
    .cfg_flat  (cfg_flat),
    .addr_flat (addr_flat)
);

// File: tb/test_memprot_unit.sv
module test_memprot_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_kind = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        rd_kind = 1'b0;
    logic [3:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic [31:0] acc_addr = '0;
    logic        acc_mach = 1'b0;
    logic [2:0]  acc_perm;
    logic        acc_hit;
    logic [3:0]  acc_region;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] seed = 32'h1234_5679;

    logic [7:0]  mc [16];
    logic [29:0] ma [16];

    always #5 clk = ~clk;

    memprot_unit i_memprot_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_idx(wr_idx), .wr_data(wr_data), .rd_kind(rd_kind), .rd_idx(rd_idx),
        .rd_data(rd_data), .acc_addr(acc_addr), .acc_mach(acc_mach),
        .acc_perm(acc_perm), .acc_hit(acc_hit), .acc_region(acc_region)
    );

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    // {hit, region[3:0], perm[2:0]} from the requirements.
    function automatic logic [7:0] model(input logic [31:0] a, input logic m);
        logic [31:0] w;
        logic        found;
        int          sel;
        logic [2:0]  p;
        w = {2'b00, a[31:2]};
        found = 1'b0;
        sel = 0;
        for (int i = 0; i < 16; i++) begin
            logic match;
            match = 1'b0;
            if (mc[i][4:3] == 2'd3) begin
                int t;
                t = 0;
                while (t < 30 && ma[i][t]) t++;
                match = (t >= 29) || ((w >> (t + 1)) == ({2'b00, ma[i]} >> (t + 1)));
            end else if (mc[i][4:3] != 2'd0) begin
                match = (w[29:0] == ma[i]);
            end
            if (match && !found) begin
                found = 1'b1;
                sel = i;
            end
        end
        if (found) p = (m && !mc[sel][7]) ? 3'b111 : mc[sel][2:0];
        else       p = m ? 3'b111 : 3'b000;
        return {found, 4'(sel), p};
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 16; i++) begin
            mc[i] = '0;
            ma[i] = '0;
        end
    endtask

    task automatic model_write(input logic k, input logic [3:0] idx, input logic [31:0] d);
        if (k == 1'b0) begin
            if (idx < 4) begin
                for (int l = 0; l < 4; l++) begin
                    if (!mc[idx*4 + l][7]) mc[idx*4 + l] = d[l*8 +: 8] & 8'h9F;
                end
            end
        end else if (!mc[idx][7]) begin
            ma[idx] = d[29:0];
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    task automatic do_write(input logic k, input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_kind = k;
        wr_idx = idx;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(k, idx, d);
    endtask

    task automatic chk_acc(input logic [31:0] a, input logic m, input string tag);
        logic [7:0] e;
        logic [7:0] got;
        acc_addr = a;
        acc_mach = m;
        #1;
        e = model(a, m);
        got = {acc_hit, acc_region, acc_perm};
        n_cmp++;
        if (got !== e) begin
            n_bad++;
            $display("FAIL %s addr=%h mach=%0b actual={hit,region,perm}=%h expected=%h",
                     tag, a, m, got, e);
        end
    endtask

    task automatic chk_rd(input logic k, input logic [3:0] idx, input logic [31:0] e, input string tag);
        rd_kind = k;
        rd_idx = idx;
        #1;
        n_cmp++;
        if (rd_data !== e) begin
            n_bad++;
            $display("FAIL %s kind=%0b idx=%0d actual=%h expected=%h", tag, k, idx, rd_data, e);
        end
    endtask

    function automatic logic [31:0] cfg_word(input int g);
        return {mc[g*4+3], mc[g*4+2], mc[g*4+1], mc[g*4]};
    endfunction

    initial begin : watchdog
        #2000000;
        n_bad++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        do_reset();

        // R1: reset contents and lookups
        for (int g = 0; g < 4; g++) chk_rd(1'b0, 4'(g), 32'h0, "R1 cfg reset");
        for (int r = 0; r < 16; r++) chk_rd(1'b1, 4'(r), 32'h0, "R1 addr reset");
        chk_acc(32'h0000_0000, 1'b1, "R1 mach reset");
        chk_acc(32'h0000_0000, 1'b0, "R1 user reset");
        chk_acc(32'hFFFF_FFFC, 1'b0, "R7 user nomatch");

        // R9: address register keeps 30 bits
        do_write(1'b1, 4'd5, 32'hFFFF_FFFF);
        chk_rd(1'b1, 4'd5, 32'h3FFF_FFFF, "R9 addr width");
        do_write(1'b1, 4'd9, 32'hC123_4567);
        chk_rd(1'b1, 4'd9, 32'h0123_4567, "R9 addr bits");

        // R8: byte packing, reserved bits, out-of-range word
        do_write(1'b0, 4'd1, 32'h7F7F_7F7F);
        chk_rd(1'b0, 4'd1, 32'h1F1F_1F1F, "R8 mask");
        do_write(1'b0, 4'd2, 32'h0A1B_1C05);
        chk_rd(1'b0, 4'd2, 32'h0A1B_1C05, "R8 lanes");
        do_write(1'b0, 4'd6, 32'h1F1F_1F1F);
        for (int g = 0; g < 4; g++) chk_rd(1'b0, 4'(g), cfg_word(g), "R8 idx>=4 no effect");
        chk_rd(1'b0, 4'd6, 32'h0, "R8 read idx>=4");
        for (int g = 0; g < 4; g++) do_write(1'b0, 4'(g), 32'h0);
        for (int r = 0; r < 16; r++) do_write(1'b1, 4'(r), 32'h0);

        // R4: every span size on region 2, perms X+R
        do_write(1'b0, 4'd0, 32'h001D_0000);
        for (int t = 0; t <= 30; t++) begin
            logic [31:0] pat;
            logic [31:0] regv;
            logic [31:0] lo;
            logic [31:0] hi;
            pat  = 32'h2B6D_5A39 & 32'h3FFF_FFFF;
            regv = (pat & ~((64'd1 << (t + 1)) - 1)) | ((64'd1 << t) - 1);
            do_write(1'b1, 4'd2, regv);
            lo = (regv & ~32'((64'd1 << (t + 1)) - 1)) << 2;
            hi = lo | (32'((64'd2 << t) - 1) << 2) | 32'h3;
            chk_acc(lo, 1'b0, "R4 span low");
            chk_acc(hi, 1'b0, "R4 span high");
            chk_acc(hi, 1'b1, "R4 span mach");
            if (t < 29) chk_acc(lo ^ (32'h1 << (t + 3)), 1'b0, "R4 just outside");
            chk_acc(rnd(), 1'b0, "R4 random probe");
        end

        // R3: exact word match in modes 1 and 2 on region 7
        do_write(1'b0, 4'd0, 32'h0);
        do_write(1'b1, 4'd7, 32'h0123_4567);
        do_write(1'b0, 4'd1, 32'h0A00_0000);
        for (int o = 0; o < 4; o++) chk_acc({32'h0123_4567, 2'b00} + o, 1'b0, "R3 word offsets");
        chk_acc({32'h0123_4568, 2'b00}, 1'b0, "R3 next word");
        chk_acc({32'h0123_4566, 2'b11}, 1'b0, "R3 previous word");
        do_write(1'b0, 4'd1, 32'h1200_0000);
        chk_acc({32'h0123_4567, 2'b10}, 1'b0, "R3 mode 2");
        chk_acc({32'h0123_4567, 2'b10}, 1'b1, "R6 mach unlocked");

        // R2: mode 0 never matches
        do_write(1'b0, 4'd1, 32'h0700_0000);
        chk_acc({32'h0123_4567, 2'b00}, 1'b0, "R2 off region");
        chk_acc({32'h0123_4567, 2'b00}, 1'b1, "R2 off region mach");

        // R5: overlap, lowest index wins
        do_write(1'b1, 4'd3, 32'h0000_0100);
        do_write(1'b1, 4'd6, 32'h0000_01FF);
        do_write(1'b0, 4'd1, 32'h001C_0000);
        do_write(1'b0, 4'd0, 32'h0900_0000);
        chk_acc(32'h0000_0400, 1'b0, "R5 low index wins");
        chk_acc(32'h0000_0404, 1'b0, "R5 only wide region");

        // R11: write and lookup in the same cycle
        for (int g = 0; g < 4; g++) do_write(1'b0, 4'(g), 32'h0);
        do_write(1'b1, 4'd0, 32'h0000_0100);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = 1'b0; wr_idx = 4'd0; wr_data = 32'h0000_000C;
        chk_acc(32'h0000_0400, 1'b0, "R11 enable old value");
        @(negedge clk);
        wr_en = 1'b0;
        model_write(1'b0, 4'd0, 32'h0000_000C);
        chk_acc(32'h0000_0400, 1'b0, "R11 enable new value");
        @(negedge clk);
        wr_en = 1'b1; wr_kind = 1'b1; wr_idx = 4'd0; wr_data = 32'h0000_0200;
        chk_acc(32'h0000_0400, 1'b0, "R11 move old value");
        @(negedge clk);
        wr_en = 1'b0;
        model_write(1'b1, 4'd0, 32'h0000_0200);
        chk_acc(32'h0000_0400, 1'b0, "R11 move new value");
        chk_acc(32'h0000_0800, 1'b0, "R11 move new place");

        // R5 R6 R7: pseudo-random mix against the model
        for (int it = 0; it < 2500; it++) begin
            logic [31:0] x;
            logic [31:0] y;
            x = rnd();
            y = rnd();
            unique case (x[1:0])
                2'd0: do_write(1'b0, {2'b00, x[3:2]}, (x[11:4] == 8'h00) ? y : (y & 32'h7F7F_7F7F));
                2'd1: do_write(1'b1, x[7:4], x[8] ? ({2'b00, ma[x[12:9]]} ^ (y & 32'hF)) : y);
                default: begin
                    logic [31:0] a;
                    a = {ma[x[7:4]], x[9:8]} ^ (x[10] ? (y & 32'h3C) : 32'h0);
                    chk_acc(a, 1'b0, "R5 R6 random user");
                    chk_acc(a, 1'b1, "R5 R6 random mach");
                    chk_acc(y, x[11], "R7 random any");
                end
            endcase
        end

        // R10: locks
        do_reset();
        do_write(1'b1, 4'd4, 32'h0000_0055);
        do_write(1'b1, 4'd5, 32'h0000_0066);
        do_write(1'b0, 4'd1, 32'h0000_0B89);
        chk_acc(32'h0000_0154, 1'b1, "R6 locked binds mach");
        @(negedge clk);
        wr_en = 1'b1; wr_kind = 1'b1; wr_idx = 4'd4; wr_data = 32'h0000_0077;
        chk_acc(32'h0000_0154, 1'b1, "R10 locked write same cycle");
        @(negedge clk);
        wr_en = 1'b0;
        model_write(1'b1, 4'd4, 32'h0000_0077);
        chk_acc(32'h0000_0154, 1'b1, "R10 locked write next cycle");
        chk_rd(1'b1, 4'd4, 32'h0000_0055, "R10 locked addr kept");
        do_write(1'b0, 4'd1, 32'h0000_1F00);
        chk_rd(1'b0, 4'd1, 32'h0000_1F89, "R10 locked byte kept, neighbour written");
        chk_acc(32'h0000_0198, 1'b0, "R10 neighbour active");
        do_reset();
        chk_rd(1'b0, 4'd1, 32'h0, "R1 reset clears lock");
        do_write(1'b1, 4'd4, 32'h0000_0077);
        chk_rd(1'b1, 4'd4, 32'h0000_0077, "R10 writable after reset");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule